// File: doc/BRIEF.md
# Configuration-Port Address Mapper

This block turns an access to the 16-bit I/O port space into the physical address that the memory side of the chip should see. Most ports fall straight through into an I/O address region. Four neighbouring ports act as a data window onto the configuration space of attached devices, and one further port holds a 32-bit selector register that steers that window.

The selector register is built into the block. It is written with a 4-byte write to its port and read back with a 4-byte read. When its top bit is set, a data-window access produces an address in the configuration region, made from the selector's device, function and register fields plus the byte lane. When that bit is clear, the window behaves like any other I/O port. Each accepted request gives exactly one registered result on the next cycle.

Top module: `cfg_port_mapper`

## Requirements
- R1: After reset, `res_valid` is 0 and the selector register holds zero. A 4-byte read of port 0xCF8 then returns 0 on `res_rdata`.
- R2: A request whose `acc_port` has any bit above bit 15 set gives `res_range_err`=1 with `res_uncached`=0, `res_intreg`=0, `res_paddr`=0 and `res_rdata`=0. It does not write the selector register.
- R3: A request to port 0xCF8 with `acc_size`=4 gives `res_intreg`=1, `res_uncached`=0 and `res_paddr`=INTREG_PADDR (default 40'h00_0000_0640).
- R4: A 4-byte write to port 0xCF8 loads `acc_wdata` into the selector register at that clock edge, so the very next request already uses the new value. A 4-byte read of port 0xCF8 returns the current selector value on `res_rdata`.
- R5: For ports 0xCFC to 0xCFF, when selector bit 31 is 1, `res_paddr` = CFG_PREFIX (default 40'h20_0000_0000) | (selector & 0x7FFF_FFFC) | port[1:0], and `res_uncached`=1.
- R6: For ports 0xCFC to 0xCFF, when selector bit 31 is 0, `res_paddr` = IO_PREFIX (default 40'h10_0000_0000) | port, and `res_uncached`=1.
- R7: Any other valid port, including 0xCF8 with a size other than 4, gives `res_paddr` = IO_PREFIX | port with `res_uncached`=1. It does not write the selector register.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `acc_valid`=1. Otherwise it is 0.
- R9: `res_rdata` is 0 for every result that is not a read of the selector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | PORT_W (32) | Port number; only the low 16 bits are legal |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data |
| res_valid | output | 1 | Result present |
| res_paddr | output | PA_W (40) | Mapped physical address |
| res_uncached | output | 1 | Access must bypass caches |
| res_intreg | output | 1 | Access hits the internal selector register |
| res_range_err | output | 1 | Port number exceeded 16 bits |
| res_rdata | output | 32 | Selector value on a selector read, else 0 |

## Verification
The hardest case to reach is a selector write followed in the very next cycle by a data-window access that must already see the new enable bit and fields. Related cases are a window access that follows a write that should have been ignored (wrong size, or an out-of-range port). The stimulus issues these requests back to back with no idle cycle between them. It toggles the enable bit in both directions and loads an all-ones selector to exercise the field mask, so any write that is a cycle late or leaks through shows up as a wrong address on the window access that follows it.

// File: rtl/cfgmap_pkg.sv
package cfgmap_pkg;
    localparam logic [15:0] SEL_PORT       = 16'hCF8;
    localparam logic [13:0] WIN_PORT_QUAD  = 14'h33F; // 0xCFC >> 2
    localparam int          SEL_EN_BIT     = 31;
    localparam logic [2:0]  SEL_ACC_BYTES  = 3'd4;

    typedef enum logic [1:0] {
        KIND_IO     = 2'd0,
        KIND_SELREG = 2'd1,
        KIND_WINDOW = 2'd2,
        KIND_RANGE  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/cfgmap_classify.sv
module cfgmap_classify
    import cfgmap_pkg::*;
#(
    parameter int PORT_W = 32
) (
    input  logic [PORT_W-1:0] port,
    input  logic [2:0]        size,
    output acc_kind_e         kind
);
    localparam int HI_W = PORT_W - 16;

    logic [15:0] low_port;
    logic        hi_set;

    generate
        if (HI_W > 0) begin : g_hi
            assign hi_set = |port[PORT_W-1:16];
        end else begin : g_nohi
            assign hi_set = 1'b0;
        end
    endgenerate

    assign low_port = port[15:0];

    always_comb begin
        if (hi_set) begin
            kind = KIND_RANGE;
        end else if (low_port == SEL_PORT && size == SEL_ACC_BYTES) begin
            kind = KIND_SELREG;
        end else if (low_port[15:2] == WIN_PORT_QUAD) begin
            kind = KIND_WINDOW;
        end else begin
            kind = KIND_IO;
        end
    end
endmodule

// File: rtl/cfgmap_sel_reg.sv
module cfgmap_sel_reg #(
    parameter int SEL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_val,
    output logic [SEL_W-1:0] sel_q
);
    logic [SEL_W-1:0] sel_d;

    always_comb begin
        sel_d = sel_q;
        if (wr_en) begin
            sel_d = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end
endmodule

// File: rtl/cfgmap_addr_form.sv
module cfgmap_addr_form
    import cfgmap_pkg::*;
#(
    parameter int          PA_W         = 40,
    parameter logic [PA_W-1:0] CFG_PREFIX   = 40'h20_0000_0000,
    parameter logic [PA_W-1:0] IO_PREFIX    = 40'h10_0000_0000,
    parameter logic [PA_W-1:0] INTREG_PADDR = 40'h00_0000_0640
) (
    input  acc_kind_e   kind,
    input  logic [15:0] low_port,
    input  logic [31:0] sel,
    output logic [PA_W-1:0] paddr,
    output logic        uncached,
    output logic        intreg,
    output logic        range_err
);
    logic [31:0] cfg_bits;
    logic [PA_W-1:0] io_addr;
    logic [PA_W-1:0] cfg_addr;

    assign cfg_bits = {1'b0, sel[30:2], low_port[1:0]};
    assign io_addr  = IO_PREFIX  | PA_W'(low_port);
    assign cfg_addr = CFG_PREFIX | PA_W'(cfg_bits);

    always_comb begin
        paddr     = '0;
        uncached  = 1'b0;
        intreg    = 1'b0;
        range_err = 1'b0;
        unique case (kind)
            KIND_RANGE: begin
                range_err = 1'b1;
            end
            KIND_SELREG: begin
                intreg = 1'b1;
                paddr  = INTREG_PADDR;
            end
            KIND_WINDOW: begin
                uncached = 1'b1;
                paddr    = sel[SEL_EN_BIT] ? cfg_addr : io_addr;
            end
            default: begin
                uncached = 1'b1;
                paddr    = io_addr;
            end
        endcase
    end
endmodule

// File: rtl/cfg_port_mapper.sv
module cfg_port_mapper
    import cfgmap_pkg::*;
#(
    parameter int          PORT_W       = 32,
    parameter int          PA_W         = 40,
    parameter logic [PA_W-1:0] CFG_PREFIX   = 40'h20_0000_0000,
    parameter logic [PA_W-1:0] IO_PREFIX    = 40'h10_0000_0000,
    parameter logic [PA_W-1:0] INTREG_PADDR = 40'h00_0000_0640
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [PORT_W-1:0] acc_port,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              res_valid,
    output logic [PA_W-1:0]   res_paddr,
    output logic              res_uncached,
    output logic              res_intreg,
    output logic              res_range_err,
    output logic [31:0]       res_rdata
);
    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            uncached;
        logic            intreg;
        logic            range_err;
        logic [31:0]     rdata;
    } res_t;

    res_t        res_d, res_q;
    acc_kind_e   kind;
    logic [31:0] sel_q;
    logic        sel_wr;
    logic [PA_W-1:0] f_paddr;
    logic        f_unc, f_int, f_err;

    cfgmap_classify #(.PORT_W(PORT_W)) u_classify (
        .port (acc_port),
        .size (acc_size),
        .kind (kind)
    );

    assign sel_wr = acc_valid && acc_write && (kind == KIND_SELREG);

    cfgmap_sel_reg #(.SEL_W(32)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel_wr),
        .wr_val (acc_wdata),
        .sel_q  (sel_q)
    );

    cfgmap_addr_form #(
        .PA_W        (PA_W),
        .CFG_PREFIX  (CFG_PREFIX),
        .IO_PREFIX   (IO_PREFIX),
        .INTREG_PADDR(INTREG_PADDR)
    ) u_form (
        .kind      (kind),
        .low_port  (acc_port[15:0]),
        .sel       (sel_q),
        .paddr     (f_paddr),
        .uncached  (f_unc),
        .intreg    (f_int),
        .range_err (f_err)
    );

    always_comb begin
        res_d = '0;
        if (acc_valid) begin
            res_d.valid     = 1'b1;
            res_d.paddr     = f_paddr;
            res_d.uncached  = f_unc;
            res_d.intreg    = f_int;
            res_d.range_err = f_err;
            if (kind == KIND_SELREG && !acc_write) begin
                res_d.rdata = sel_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid     = res_q.valid;
    assign res_paddr     = res_q.paddr;
    assign res_uncached  = res_q.uncached;
    assign res_intreg    = res_q.intreg;
    assign res_range_err = res_q.range_err;
    assign res_rdata     = res_q.rdata;
endmodule

// File: rtl/cfg_port_mapper_chk.sv
module cfg_port_mapper_chk #(
    parameter int          PORT_W     = 32,
    parameter int          PA_W       = 40,
    parameter logic [PA_W-1:0] CFG_PREFIX = 40'h20_0000_0000,
    parameter logic [PA_W-1:0] IO_PREFIX  = 40'h10_0000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [PORT_W-1:0] acc_port,
    input logic [2:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic              res_valid,
    input logic [PA_W-1:0]   res_paddr,
    input logic              res_uncached,
    input logic              res_intreg,
    input logic              res_range_err,
    input logic [31:0]       res_rdata
);
    logic sel_acc;
    assign sel_acc = acc_valid && (acc_port == PORT_W'(16'hCF8)) && (acc_size == 3'd4);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);
    assert_range_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_range_err) |-> (!res_intreg && !res_uncached && res_paddr == '0));
    assert_selreg_cached_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_intreg) |-> (!res_uncached && !res_range_err));
    assert_io_uncached_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_intreg && !res_range_err) |-> res_uncached);
    assert_region_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(((res_paddr & CFG_PREFIX) != '0) && ((res_paddr & IO_PREFIX) != '0)));
    assert_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_intreg) |-> (res_rdata == '0));
    assert_write_then_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_acc && acc_write) ##1 (sel_acc && !acc_write) |=> (res_rdata == $past(acc_wdata, 2)));
endmodule

bind cfg_port_mapper cfg_port_mapper_chk #(
    .PORT_W    (PORT_W),
    .PA_W      (PA_W),
    .CFG_PREFIX(CFG_PREFIX),
    .IO_PREFIX (IO_PREFIX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_port     (acc_port),
    .acc_size     (acc_size),
    .acc_wdata    (acc_wdata),
    .res_valid    (res_valid),
    .res_paddr    (res_paddr),
    .res_uncached (res_uncached),
    .res_intreg   (res_intreg),
    .res_range_err(res_range_err),
    .res_rdata    (res_rdata)
);

// File: tb/cfg_port_mapper_bench.sv
`timescale 1ns/1ps
module cfg_port_mapper_bench;
    localparam logic [39:0] CFGP = 40'h20_0000_0000;
    localparam logic [39:0] IOP  = 40'h10_0000_0000;
    localparam logic [39:0] INTP = 40'h00_0000_0640;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_port = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        res_valid;
    logic [39:0] res_paddr;
    logic        res_uncached, res_intreg, res_range_err;
    logic [31:0] res_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cfg_port_mapper u_cfg_port_mapper (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_port(acc_port), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_uncached(res_uncached),
        .res_intreg(res_intreg), .res_range_err(res_range_err), .res_rdata(res_rdata)
    );

    typedef struct {
        logic [39:0] pa;
        bit          unc;
        bit          intr;
        bit          err;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] msel = '0;

    task automatic acc(input bit w, input logic [31:0] port, input logic [2:0] sz,
                       input logic [31:0] data, input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_port = port; acc_size = sz; acc_wdata = data;
        e.pa = '0; e.unc = 0; e.intr = 0; e.err = 0; e.rd = '0; e.tag = tag;
        if (port[31:16] != 16'h0) begin
            e.err = 1;
        end else if (port[15:0] == 16'hCF8 && sz == 3'd4) begin
            e.intr = 1; e.pa = INTP;
            if (!w) e.rd = msel;
            else msel = data;
        end else if (port[15:0] >= 16'hCFC && port[15:0] <= 16'hCFF) begin
            e.unc = 1;
            if (msel[31]) e.pa = CFGP | {8'h0, 1'b0, msel[30:2], port[1:0]};
            else          e.pa = IOP | {24'h0, port[15:0]};
        end else begin
            e.unc = 1; e.pa = IOP | {24'h0, port[15:0]};
        end
        sb.push_back(e);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: res_valid actual=%0b expected=0", tag, res_valid);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R8: unexpected result actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_paddr !== e.pa || res_uncached !== e.unc || res_intreg !== e.intr ||
                    res_range_err !== e.err || res_rdata !== e.rd) begin
                    fails++;
                    $display("FAIL %s: actual pa=%h unc=%0b int=%0b err=%0b rd=%h expected pa=%h unc=%0b int=%0b err=%0b rd=%h",
                             e.tag, res_paddr, res_uncached, res_intreg, res_range_err, res_rdata,
                             e.pa, e.unc, e.intr, e.err, e.rd);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: res_valid in reset actual=%0b expected=0", res_valid);
        end
        rst_n = 1'b1;
        acc(0, 32'h0CF8, 3'd4, 32'h0, "R1 R3 reset selector read");
        acc(0, 32'h03F8, 3'd1, 32'h0, "R7 plain port");
        acc(0, 32'h0CFC, 3'd4, 32'h0, "R6 window disabled");
        idle_check("R8 idle");
        acc(1, 32'h0CF8, 3'd4, 32'h8000_1234, "R4 selector write");
        acc(0, 32'h0CFE, 3'd2, 32'h0, "R5 window enabled back-to-back");
        acc(0, 32'h0CF8, 3'd4, 32'h0, "R4 selector readback");
        acc(1, 32'h0CFF, 3'd1, 32'hAB, "R5 window write lane 3");
        acc(1, 32'h0CF8, 3'd2, 32'h0, "R7 selector port wrong size");
        acc(0, 32'h0CFD, 3'd1, 32'h0, "R7 selector unchanged");
        acc(1, 32'h1_0CF8, 3'd4, 32'h0, "R2 out-of-range port");
        acc(0, 32'h0CF8, 3'd4, 32'h0, "R2 selector unchanged");
        acc(0, 32'h8000_0070, 3'd1, 32'h0, "R2 top bit port");
        acc(1, 32'h0CF8, 3'd4, 32'h7FFF_FFFF, "R4 disable write");
        acc(0, 32'h0CFC, 3'd4, 32'h0, "R6 window after disable");
        acc(1, 32'h0CF8, 3'd4, 32'hFFFF_FFFF, "R4 all-ones write");
        acc(0, 32'h0CFF, 3'd1, 32'h0, "R5 field mask all ones");
        acc(0, 32'h0CFB, 3'd1, 32'h0, "R7 just below window");
        acc(1, 32'hFFFF, 3'd2, 32'h5, "R9 write to top port");
        idle_check("R8 idle end");
        repeat (2) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8: pending results actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule